// File: doc/BRIEF.md
# SPI Configuration Write Port

This block lets a host processor load a bank of 8-bit configuration registers over a write-only SPI link. It watches chip select, serial clock and serial data. These pins may be fully asynchronous to the system clock, so the block brings each one into the system clock domain through a synchroniser chain and detects serial-clock edges there. Each frame that is accepted produces one write pulse per data byte. The pulse carries the register index and the data, and an external register bank acts on it.

A frame begins when chip select goes low. The first byte holds a 7-bit device address in its upper bits and a direction flag in its lowest bit. The second byte is a pointer byte. It holds a register index and an auto-increment flag. Every complete byte after that is data. With auto-increment set, a burst of bytes fills consecutive registers. With it clear, every byte of the burst lands on the same register.

The block also keeps a sticky indicator that the control port is in SPI mode. The indicator sets on the first falling edge of chip select after reset and stays set until the next reset.

Top module: `spi_cfg_port`

## Requirements
- R1: Serial data is captured on each rising serial-clock edge seen while chip select is low, and each byte is assembled most significant bit first.
- R2: A frame is accepted only when bits 7:1 of its first byte equal the device address (default 7'b0010000). Any other value causes no write for the rest of the frame.
- R3: Bit 0 of the first byte is the direction flag. A value of 1 (read) causes the whole frame to be ignored, so no write pulse is produced.
- R4: The second byte of an accepted frame loads the pointer. Bits 6:0 are the register index and bit 7 is the auto-increment flag.
- R5: Each complete data byte whose index is below NUM_REGS produces a single-cycle wrStrobe, with wrIndex and wrData valid in that cycle. An index of NUM_REGS or above produces no pulse.
- R6: With the auto-increment flag at 0, every data byte of the frame goes to the same index.
- R7: With the auto-increment flag at 1, the index advances by one after each data byte and wraps from 127 to 0.
- R8: Chip select going high discards any partial byte and returns the frame to its first byte. Serial-clock edges while chip select is high have no effect.
- R9: spiMode is 0 after reset. It becomes 1 after the first high-to-low transition of chip select and then holds at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| spiCsN | input | 1 | Chip select, active low, asynchronous |
| spiSclk | input | 1 | Serial clock, asynchronous |
| spiSdi | input | 1 | Serial data in, asynchronous |
| wrStrobe | output | 1 | One-cycle register write pulse |
| wrIndex | output | $clog2(NUM_REGS) | Index of the register being written |
| wrData | output | 8 | Byte being written |
| spiMode | output | 1 | Sticky SPI-mode indicator |

## Verification
The bench builds the block with NUM_REGS = 8, the default device address and two synchroniser stages. With only eight registers, a sweep across all 128 pointer indices covers both the pulses for in-range indices and the silence for out-of-range ones in a short run. The same sweep width covers every device address value. Short bursts that start at indices 5 and 126 cross the range limit and the 127-to-0 wrap within four or five bytes.

// File: rtl/spicfg_pkg.sv
package spicfg_pkg;

  typedef enum logic [1:0] {
    ST_ADDR   = 2'd0,
    ST_PTR    = 2'd1,
    ST_DATA   = 2'd2,
    ST_IGNORE = 2'd3
  } frameState_t;

  typedef struct packed {
    logic shiftEn;
    logic loadPtr;
    logic writeByte;
  } ctrlStrobes_t;

endpackage

// File: rtl/spicfg_datapath.sv
module spicfg_datapath
  import spicfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b0010000,
  parameter int         NUM_REGS    = 8,
  parameter int         SYNC_STAGES = 2,
  localparam int        IDX_W       = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csIn,
  input  logic             sclkIn,
  input  logic             sdiIn,
  input  ctrlStrobes_t     ctl,
  output logic             sclkRise,
  output logic             csHigh,
  output logic             csFall,
  output logic             addrOk,
  output logic             wrStrobe,
  output logic [IDX_W-1:0] wrIndex,
  output logic [7:0]       wrData
);

  localparam int         NUM_PINS  = 3;
  localparam logic [2:0] RESET_VAL = 3'b100;
  localparam logic [7:0] REG_LIMIT = 8'(NUM_REGS);

  logic [NUM_PINS-1:0] rawIn;
  logic [NUM_PINS-1:0] synced;
  assign rawIn = {csIn, sclkIn, sdiIn};

  for (genvar g = 0; g < NUM_PINS; g++) begin : gSync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= {SYNC_STAGES{RESET_VAL[g]}};
      else       chain <= {chain[SYNC_STAGES-2:0], rawIn[g]};
    end
    assign synced[g] = chain[SYNC_STAGES-1];
  end

  logic csSync, sclkSync, sdiSync;
  logic csPrev, sclkPrev;
  assign csSync   = synced[2];
  assign sclkSync = synced[1];
  assign sdiSync  = synced[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csPrev   <= csSync;
      sclkPrev <= sclkSync;
    end
  end

  assign sclkRise = sclkSync & ~sclkPrev & ~csSync;
  assign csFall   = csPrev & ~csSync;
  assign csHigh   = csSync;

  logic [6:0] shiftReg;
  logic [7:0] byteNow;
  logic [7:0] ptrReg;
  logic [6:0] ptrIdx;
  logic       ptrIncr;
  logic       inRange;

  assign byteNow = {shiftReg, sdiSync};
  assign addrOk  = (byteNow[7:1] == DEV_ADDR) && !byteNow[0];
  assign ptrIdx  = ptrReg[6:0];
  assign ptrIncr = ptrReg[7];
  assign inRange = {1'b0, ptrIdx} < REG_LIMIT;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (ctl.shiftEn) shiftReg <= byteNow[6:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrReg <= '0;
    end else if (ctl.loadPtr) begin
      ptrReg <= byteNow;
    end else if (ctl.writeByte && ptrIncr) begin
      ptrReg[6:0] <= ptrIdx + 7'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrStrobe <= 1'b0;
      wrIndex  <= '0;
      wrData   <= '0;
    end else begin
      wrStrobe <= ctl.writeByte && inRange;
      if (ctl.writeByte) begin
        wrIndex <= ptrIdx[IDX_W-1:0];
        wrData  <= byteNow;
      end
    end
  end

  // R5: the write pulse never lasts more than one cycle
  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);

  // R5: a write to an index past the bank gives no pulse
  assert_no_oob_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.writeByte && !inRange) |=> !wrStrobe);

  // R6: pointer holds when auto-increment is off
  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.writeByte && !ptrIncr) |=> ptrIdx == $past(ptrIdx));

  // R7: pointer advances by one, modulo 128, when auto-increment is on
  assert_ptr_adv_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.writeByte && ptrIncr) |=> ptrIdx == 7'($past(ptrIdx) + 7'd1));

  // R8: no serial-clock edge is reported while chip select is high
  assert_no_edge_cs_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    csHigh |-> !sclkRise);

endmodule

// File: rtl/spicfg_control.sv
module spicfg_control
  import spicfg_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclkRise,
  input  logic         csHigh,
  input  logic         csFall,
  input  logic         addrOk,
  output ctrlStrobes_t ctl,
  output logic         spiMode
);

  localparam int         CNT_W    = 3;
  localparam logic [2:0] LAST_BIT = 3'(7);

  frameState_t      state;
  logic [CNT_W-1:0] bitCnt;
  logic             byteDone;

  assign byteDone = sclkRise && (bitCnt == LAST_BIT);

  always_comb begin
    ctl = '0;
    if (sclkRise) begin
      ctl.shiftEn = 1'b1;
      if (byteDone) begin
        ctl.loadPtr   = (state == ST_PTR);
        ctl.writeByte = (state == ST_DATA);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
    end else if (csHigh) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
    end else if (sclkRise) begin
      bitCnt <= bitCnt + 3'd1;
      if (byteDone) begin
        unique case (state)
          ST_ADDR:   state <= addrOk ? ST_PTR : ST_IGNORE;
          ST_PTR:    state <= ST_DATA;
          ST_DATA:   state <= ST_DATA;
          ST_IGNORE: state <= ST_IGNORE;
          default:   state <= ST_IGNORE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       spiMode <= 1'b0;
    else if (csFall) spiMode <= 1'b1;
  end

  // R1: bit counter moves only on a captured serial-clock edge
  assert_bitcnt_stable_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!sclkRise && !csHigh) |=> $stable(bitCnt));

  // R3: a rejected frame never requests a write
  assert_ignore_silent_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE) |-> !ctl.writeByte);

  // R8: chip select high restarts the frame
  assert_cs_abort_R8: assert property (@(posedge clk) disable iff (!rstN)
    csHigh |=> (bitCnt == '0) && (state == ST_ADDR));

  // R9: the mode indicator never clears without reset
  assert_mode_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    spiMode |=> spiMode);

  // R9: the mode indicator rises only on a chip-select fall
  assert_mode_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiMode) |-> $past(csFall));

endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
  import spicfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b0010000,
  parameter int         NUM_REGS    = 8,
  parameter int         SYNC_STAGES = 2,
  localparam int        IDX_W       = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             spiCsN,
  input  logic             spiSclk,
  input  logic             spiSdi,
  output logic             wrStrobe,
  output logic [IDX_W-1:0] wrIndex,
  output logic [7:0]       wrData,
  output logic             spiMode
);

  ctrlStrobes_t ctl;
  logic sclkRise, csHigh, csFall, addrOk;

  spicfg_datapath #(
    .DEV_ADDR   (DEV_ADDR),
    .NUM_REGS   (NUM_REGS),
    .SYNC_STAGES(SYNC_STAGES)
  ) uDatapath (
    .clk     (clk),
    .rstN    (rstN),
    .csIn    (spiCsN),
    .sclkIn  (spiSclk),
    .sdiIn   (spiSdi),
    .ctl     (ctl),
    .sclkRise(sclkRise),
    .csHigh  (csHigh),
    .csFall  (csFall),
    .addrOk  (addrOk),
    .wrStrobe(wrStrobe),
    .wrIndex (wrIndex),
    .wrData  (wrData)
  );

  spicfg_control uControl (
    .clk     (clk),
    .rstN    (rstN),
    .sclkRise(sclkRise),
    .csHigh  (csHigh),
    .csFall  (csFall),
    .addrOk  (addrOk),
    .ctl     (ctl),
    .spiMode (spiMode)
  );

endmodule

// File: tb/spi_cfg_port_test.sv
module spi_cfg_port_test;

  localparam int         NREG = 8;
  localparam int         HALF = 4;
  localparam logic [6:0] DEV  = 7'b0010000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       spiCsN = 1'b1;
  logic       spiSclk = 1'b0;
  logic       spiSdi = 1'b0;
  logic       wrStrobe;
  logic [2:0] wrIndex;
  logic [7:0] wrData;
  logic       spiMode;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int capIdx [0:31];
  int capData[0:31];
  int capN = 0;
  int expIdx [0:31];
  int expData[0:31];
  int expN = 0;

  always #2.5 clk = ~clk;

  spi_cfg_port #(.DEV_ADDR(DEV), .NUM_REGS(NREG), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiSclk(spiSclk), .spiSdi(spiSdi),
    .wrStrobe(wrStrobe), .wrIndex(wrIndex), .wrData(wrData), .spiMode(spiMode)
  );

  always @(negedge clk) begin
    if (wrStrobe && capN < 32) begin
      capIdx[capN]  = int'(wrIndex);
      capData[capN] = int'(wrData);
      capN++;
    end
  end

  function automatic logic [7:0] dataVal(input int seed, input int k);
    return 8'(seed * 29 + k * 71 + 13);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendBits(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk); spiSdi = v[i];
      repeat (HALF) @(negedge clk);
      spiSclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spiSclk = 1'b0;
    end
  endtask

  task automatic csLow();
    @(negedge clk); spiCsN = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic csHighWait();
    repeat (12) @(negedge clk);
    spiCsN = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  // expected writes from the requirements: R2, R3, R4, R5, R6, R7
  task automatic buildExpect(input logic [7:0] b0, input logic [7:0] b1,
                             input int nData, input int seed);
    bit accept = (b0[7:1] == DEV) && !b0[0];
    int idx = int'(b1[6:0]);
    expN = 0;
    for (int k = 0; k < nData; k++) begin
      if (accept && idx < NREG) begin
        expIdx[expN]  = idx;
        expData[expN] = int'(dataVal(seed, k));
        expN++;
      end
      if (b1[7]) idx = (idx + 1) % 128;
    end
  endtask

  task automatic compareWrites(input string req);
    check(capN == expN, {req, " write count"}, capN, expN);
    for (int i = 0; i < expN && i < capN; i++) begin
      check(capIdx[i] == expIdx[i], {req, " index"}, capIdx[i], expIdx[i]);
      check(capData[i] == expData[i], {req, " data"}, capData[i], expData[i]);
    end
    capN = 0;
  endtask

  task automatic runFrame(input logic [7:0] b0, input logic [7:0] b1,
                          input int nData, input int seed, input string req);
    buildExpect(b0, b1, nData, seed);
    capN = 0;
    csLow();
    sendBits(b0, 8);
    sendBits(b1, 8);
    for (int k = 0; k < nData; k++) sendBits(dataVal(seed, k), 8);
    csHighWait();
    compareWrites(req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R9: reset state
    check(spiMode == 1'b0, "R9 mode after reset", int'(spiMode), 0);
    check(wrStrobe == 1'b0, "R5 strobe after reset", int'(wrStrobe), 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(spiMode == 1'b0, "R9 mode before cs fall", int'(spiMode), 0);

    // R1 R4 R5: sweep every pointer index, single byte, no increment
    for (int i = 0; i < 128; i++)
      runFrame({DEV, 1'b0}, 8'(i), 1, i, "R1/R4/R5 index sweep");
    check(spiMode == 1'b1, "R9 mode after cs fall", int'(spiMode), 1);

    // R6: burst without increment hits one register
    runFrame({DEV, 1'b0}, 8'h03, 4, 200, "R6 fixed pointer burst");

    // R7 R5: increment burst crossing the bank limit
    runFrame({DEV, 1'b0}, 8'h85, 5, 201, "R7 burst over limit");

    // R7: increment wrap from 127 to 0
    runFrame({DEV, 1'b0}, 8'hFE, 4, 202, "R7 wrap");

    // R2: sweep every device address
    for (int a = 0; a < 128; a++)
      runFrame({7'(a), 1'b0}, 8'h82, 2, 300 + a, "R2 address sweep");

    // R3: read flag with a matching address
    runFrame({DEV, 1'b1}, 8'h01, 3, 400, "R3 read flag");

    // R8: partial first byte then chip select high, then a clean frame
    capN = 0;
    csLow();
    sendBits({DEV, 1'b0}, 5);
    csHighWait();
    check(capN == 0, "R8 abort in address byte", capN, 0);
    runFrame({DEV, 1'b0}, 8'h84, 2, 500, "R8 frame after abort");

    // R8: abort partway through a data byte
    buildExpect({DEV, 1'b0}, 8'h86, 1, 501);
    capN = 0;
    csLow();
    sendBits({DEV, 1'b0}, 8);
    sendBits(8'h86, 8);
    sendBits(dataVal(501, 0), 8);
    sendBits(dataVal(501, 1), 4);
    csHighWait();
    compareWrites("R8 abort in data byte");

    // R8: serial clock toggles while chip select is high
    capN = 0;
    for (int t = 0; t < 16; t++) begin
      @(negedge clk); spiSdi = t[0];
      repeat (HALF) @(negedge clk); spiSclk = 1'b1;
      repeat (HALF) @(negedge clk); spiSclk = 1'b0;
    end
    repeat (12) @(negedge clk);
    check(capN == 0, "R8 clocks with cs high", capN, 0);
    runFrame({DEV, 1'b0}, 8'h07, 1, 502, "R8 frame after idle clocks");

    // R9: reset clears the mode, next cs fall sets it again
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(spiMode == 1'b0, "R9 mode cleared by reset", int'(spiMode), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    runFrame({DEV, 1'b0}, 8'h01, 1, 600, "R9 frame after reset");
    check(spiMode == 1'b1, "R9 mode set again", int'(spiMode), 1);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule